// File: doc/BRIEF.md
# Pipelined Burst SRAM Without Bus Turnaround

This block models a synchronous static RAM whose every command is registered on the rising clock edge. Read data leaves an output register two enabled edges after its address. Write data is taken two enabled edges after its address. Because reads and writes both use the same two-edge spacing, the data bus never needs an idle cycle when the traffic switches between reading and writing. A command may be issued on every cycle in any mix.

A command either loads a fresh address or continues the burst in progress. A continue takes its address from a small burst sequencer, which steps through the four words of an aligned group in linear or interleaved order. The sequencer wraps back to the starting word. Writes are masked per 9-bit byte lane. A read that follows a write to the same word, before that write's data has been stored, sees the new data merged lane by lane with the stored word. A clock-enable input freezes the whole pipeline. An output-enable input gates the data-valid flag without any clock. A sleep request shuts off every input other than itself, while the array keeps its contents.

Top module: `pipe_sram`

## Requirements
- R1: On an edge where `clken_n` is low, `load_n` is low and `ce_n` is low, a new access starts at `addr`. It is a read when `wr_n` is high and a write when `wr_n` is low. A read and a write may be issued on consecutive cycles in any mix, with no idle cycle between them.
- R2: A read's data appears on `dout` with `dout_vld` high right after the second enabled edge following its address edge. It holds there until the next enabled edge.
- R3: A write's data is sampled from `din` on the second enabled edge following its address edge.
- R4: Lane i covers bits [9i+8:9i]. A write stores lane i only when `lanes_n[i]` is low. When all four `lanes_n` bits are high, the write stores nothing.
- R5: With `burst_xor` low, a cycle with `load_n` high inside a burst performs another access of the same kind. Its address keeps the upper bits of the loaded address, and its low two bits are (start + k) mod 4 for the k-th continue. `ce_n` is not looked at on a continue.
- R6: With `burst_xor` high, the low two address bits of the k-th continue are (start XOR k).
- R7: An edge with `load_n` low and `ce_n` high starts no access and ends any burst. Later edges with `load_n` high then start no access, whatever `wr_n` and `lanes_n` show.
- R8: While `clken_n` is high, every synchronous input is ignored and all state holds, including pending writes and `dout`/`dout_vld`.
- R9: `out_en_n` acts without a clock. While it is high, `dout_vld` is low, so a read issued in that time is a dummy read that presents nothing.
- R10: A read issued on the cycle right after a write to the same address returns the written lanes merged with the stored lanes of that word.
- R11: Sleep begins with the third edge after `sleep_req` rises, and it ends two edges after `sleep_req` falls. During sleep, every other input is ignored, pending accesses are dropped, `dout_vld` is low, and the array contents are kept.
- R12: Right after reset, `dout_vld` is low, nothing is pending, and the block is deselected. Cycles with `load_n` high start no access until an address is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | log2(DEPTH) | Word address, taken when an access is loaded |
| ce_n | input | 1 | Active-low chip enable, looked at on load cycles |
| load_n | input | 1 | Low: load a new access or deselect; high: continue |
| wr_n | input | 1 | High: read, low: write (load cycles) |
| lanes_n | input | LANES | Active-low per-lane write strobes |
| clken_n | input | 1 | Active-low clock enable; high freezes the block |
| out_en_n | input | 1 | Active-low output enable, combinational |
| sleep_req | input | 1 | Sleep request, active high |
| burst_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| din | input | LANES*LANE_W | Write data, two edges after its address |
| dout | output | LANES*LANE_W | Read data, zero while not valid |
| dout_vld | output | 1 | Read data on `dout` is valid and enabled |

## Verification
The bench builds the block with DEPTH=16 and the default four 9-bit lanes. At that size it can write and read back every word. Across sixteen words it applies all sixteen lane-strobe patterns, each followed at once by a read, so both the forwarding merge and the write-abort pattern are covered. It runs every start offset of a four-word group in both burst orders. The small array also makes it cheap to sweep the whole array after freezes, deselected continues and sleep, which shows that none of them changed any stored word.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

    // Burst groups are four words: two low address bits are sequenced.
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_RD   = 2'd1,
        MODE_WR   = 2'd2
    } burst_mode_e;

    // Low address bits for step k of a burst from a given start word.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               interleave
    );
        return interleave ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/nbl_burst_seq.sv
module nbl_burst_seq
    import nbl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_en,
    input  logic          load,
    input  logic          advance,
    input  logic          interleave,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] next_addr
);

    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_inc;

    assign cnt_inc   = cnt_q + BURST_W'(1);
    assign next_addr = {base_q[AW-1:BURST_W],
                        burst_low(base_q[BURST_W-1:0], cnt_inc, interleave)};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (step_en) begin
            if (load) begin
                base_q <= start_addr;
                cnt_q  <= '0;
            end else if (advance) begin
                cnt_q <= cnt_inc;
            end
        end
    end

    // R5
    seq_group_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && load) |=> next_addr[AW-1:BURST_W] == $past(start_addr[AW-1:BURST_W]));

endmodule

// File: rtl/nbl_cmd_decode.sv
module nbl_cmd_decode
    import nbl_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             flush,
    input  logic             load_n,
    input  logic             ce_n,
    input  logic             wr_n,
    input  logic [AW-1:0]    addr,
    input  logic [AW-1:0]    seq_addr,
    input  logic [LANES-1:0] lanes_in_n,
    output op_e              kind,
    output logic [AW-1:0]    op_addr,
    output logic [LANES-1:0] op_lanes_n,
    output logic             seq_load,
    output logic             seq_adv
);

    burst_mode_e mode_q;
    burst_mode_e mode_d;

    always_comb begin
        kind       = OP_NONE;
        op_addr    = addr;
        op_lanes_n = lanes_in_n;
        seq_load   = 1'b0;
        seq_adv    = 1'b0;
        mode_d     = mode_q;
        if (!load_n) begin
            if (ce_n) begin
                mode_d = MODE_IDLE;
            end else begin
                seq_load = 1'b1;
                kind     = wr_n ? OP_READ : OP_WRITE;
                mode_d   = wr_n ? MODE_RD : MODE_WR;
            end
        end else begin
            op_addr = seq_addr;
            case (mode_q)
                MODE_RD: begin
                    kind    = OP_READ;
                    seq_adv = 1'b1;
                end
                MODE_WR: begin
                    kind    = OP_WRITE;
                    seq_adv = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            mode_q <= MODE_IDLE;
        end else if (step_en) begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/nbl_lane_merge.sv
module nbl_lane_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    old_word,
    input  logic [DW-1:0]    new_word,
    input  logic [LANES-1:0] lanes_n,
    output logic [DW-1:0]    merged
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = lanes_n[i] ? old_word[i*LANE_W +: LANE_W]
                                                       : new_word[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import nbl_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             ce_n,
    input  logic             load_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lanes_n,
    input  logic             clken_n,
    input  logic             out_en_n,
    input  logic             sleep_req,
    input  logic             burst_xor,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_vld
);

    typedef struct packed {
        op_e              kind;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] lanes_n;
    } stage_t;

    // Sleep request delay line: sleep state follows the request by two edges.
    logic [1:0] zz_q;
    logic       asleep;
    logic       go;

    always_ff @(posedge clk) begin
        if (rst) zz_q <= '0;
        else     zz_q <= {zz_q[0], sleep_req};
    end

    assign asleep = zz_q[1];
    assign go     = !clken_n && !asleep;

    // Command decode and burst address generation.
    stage_t        dec_stage;
    op_e           dec_kind;
    logic [AW-1:0] dec_addr;
    logic [LANES-1:0] dec_lanes_n;
    logic [AW-1:0] seq_addr;
    logic          seq_load;
    logic          seq_adv;

    nbl_burst_seq #(.AW(AW)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .step_en    (go),
        .load       (seq_load),
        .advance    (seq_adv),
        .interleave (burst_xor),
        .start_addr (addr),
        .next_addr  (seq_addr)
    );

    nbl_cmd_decode #(.AW(AW), .LANES(LANES)) i_dec (
        .clk        (clk),
        .rst        (rst),
        .step_en    (go),
        .flush      (asleep),
        .load_n     (load_n),
        .ce_n       (ce_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .seq_addr   (seq_addr),
        .lanes_in_n (lanes_n),
        .kind       (dec_kind),
        .op_addr    (dec_addr),
        .op_lanes_n (dec_lanes_n),
        .seq_load   (seq_load),
        .seq_adv    (seq_adv)
    );

    assign dec_stage = '{kind: dec_kind, addr: dec_addr, lanes_n: dec_lanes_n};

    // Storage and the two-stage command pipeline.
    logic [DW-1:0] mem [DEPTH];
    stage_t        s1_q;
    stage_t        s2_q;
    logic [DW-1:0] s2_data_q;
    logic [DW-1:0] out_q;
    logic          out_vld_q;

    logic [DW-1:0] wr_word;
    logic [DW-1:0] arr_word;
    logic [DW-1:0] fwd_word;
    logic          fwd_hit;

    // Write completing this edge: stored lanes merged with the late data.
    nbl_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) i_merge (
        .old_word (mem[s2_q.addr]),
        .new_word (din),
        .lanes_n  (s2_q.lanes_n),
        .merged   (wr_word)
    );

    // A read sampling the array on the same edge sees the completing write.
    assign arr_word = mem[s1_q.addr];
    assign fwd_hit  = (s2_q.kind == OP_WRITE) && (s2_q.addr == s1_q.addr);
    assign fwd_word = fwd_hit ? wr_word : arr_word;

    always_ff @(posedge clk) begin
        if (go && s2_q.kind == OP_WRITE) begin
            mem[s2_q.addr] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= '0;
            s2_q      <= '0;
            s2_data_q <= '0;
            out_q     <= '0;
            out_vld_q <= 1'b0;
        end else if (asleep) begin
            s1_q.kind <= OP_NONE;
            s2_q.kind <= OP_NONE;
            out_vld_q <= 1'b0;
        end else if (!clken_n) begin
            s1_q      <= dec_stage;
            s2_q      <= s1_q;
            s2_data_q <= fwd_word;
            out_vld_q <= (s2_q.kind == OP_READ);
            out_q     <= s2_data_q;
        end
    end

    assign dout_vld = out_vld_q && !out_en_n && !asleep;
    assign dout     = dout_vld ? out_q : '0;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (clken_n && !asleep) |=> ($stable(s1_q) && $stable(s2_q) &&
                                  $stable(out_vld_q) && $stable(out_q)));

    // R11
    sleep_flush_chk: assert property (@(posedge clk) disable iff (rst)
        asleep |=> (s1_q.kind == OP_NONE && s2_q.kind == OP_NONE && !out_vld_q));

    // R3
    write_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        (go && s1_q.kind == OP_WRITE) |=> (s2_q.kind == OP_WRITE && s2_q.addr == $past(s1_q.addr)));

    // R2
    read_out_chk: assert property (@(posedge clk) disable iff (rst)
        (go && s2_q.kind == OP_READ) |=> out_vld_q);

    // R7
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !load_n && ce_n) |=> s1_q.kind == OP_NONE);

endmodule

// File: tb/test_pipe_sram.sv
module test_pipe_sram;

    localparam int DEPTH  = 16;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;
    localparam int AW     = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic [AW-1:0]    addr;
    logic             ce_n;
    logic             load_n;
    logic             wr_n;
    logic [LANES-1:0] lanes_n;
    logic             clken_n;
    logic             out_en_n;
    logic             sleep_req;
    logic             burst_xor;
    logic [DW-1:0]    din;
    logic [DW-1:0]    dout;
    logic             dout_vld;

    pipe_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_pipe_sram (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .ce_n      (ce_n),
        .load_n    (load_n),
        .wr_n      (wr_n),
        .lanes_n   (lanes_n),
        .clken_n   (clken_n),
        .out_en_n  (out_en_n),
        .sleep_req (sleep_req),
        .burst_xor (burst_xor),
        .din       (din),
        .dout      (dout),
        .dout_vld  (dout_vld)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Bench model: expected array and the two accesses still in flight.
    logic [DW-1:0] ref_mem [DEPTH];
    int            p1_kind = 0;
    int            p2_kind = 0;
    logic [DW-1:0] p1_val  = '0;
    logic [DW-1:0] p2_val  = '0;
    string         p1_req  = "R12";
    string         p2_req  = "R12";

    function automatic logic [DW-1:0] merge_f(input logic [DW-1:0] old_w,
                                              input logic [DW-1:0] new_w,
                                              input logic [LANES-1:0] ln);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < LANES; i++)
            if (!ln[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int seed);
        return (DW'(seed) * 36'h0_2468_ACE1) ^ 36'h9_5A5A_5A5A;
    endfunction

    task automatic checkw(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One enabled cycle. mk: 0 none, 1 read, 2 write; ma is the model address.
    task automatic issue(input logic ld_n, input logic c_n, input logic w_n,
                         input logic [AW-1:0] a, input logic [LANES-1:0] ln,
                         input int mk, input logic [AW-1:0] ma,
                         input logic [DW-1:0] wd, input string req);
        @(negedge clk);
        load_n  = ld_n;
        ce_n    = c_n;
        wr_n    = w_n;
        addr    = a;
        lanes_n = ln;
        clken_n = 1'b0;
        din     = (p2_kind == 2) ? p2_val : '1;
        @(posedge clk);
        #1;
        if (p2_kind == 1) begin
            check1(p2_req, dout_vld, !out_en_n);
            if (!out_en_n) checkw(p2_req, dout, p2_val);
        end else begin
            check1(p2_req, dout_vld, 1'b0);
        end
        p2_kind = p1_kind;
        p2_val  = p1_val;
        p2_req  = p1_req;
        p1_kind = mk;
        p1_req  = req;
        if (mk == 1) begin
            p1_val = ref_mem[ma];
        end else if (mk == 2) begin
            p1_val      = wd;
            ref_mem[ma] = merge_f(ref_mem[ma], wd, ln);
        end else begin
            p1_val = '0;
        end
    endtask

    task automatic wr1(input int a, input logic [LANES-1:0] ln, input logic [DW-1:0] d, input string req);
        issue(1'b0, 1'b0, 1'b0, AW'(a), ln, 2, AW'(a), d, req);
    endtask

    task automatic rd1(input int a, input string req);
        issue(1'b0, 1'b0, 1'b1, AW'(a), 4'hF, 1, AW'(a), '0, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(1'b0, 1'b1, 1'b1, '0, 4'hF, 0, '0, '0, "R7");
    endtask

    // A frozen cycle with hostile inputs; outputs must not move (R8).
    task automatic stall();
        logic          pv;
        logic [DW-1:0] pd;
        @(negedge clk);
        pv      = dout_vld;
        pd      = dout;
        clken_n = 1'b1;
        load_n  = 1'b0;
        ce_n    = 1'b0;
        wr_n    = 1'b0;
        addr    = AW'(13);
        lanes_n = '0;
        din     = 36'h7_0F0F_0F0F;
        @(posedge clk);
        #1;
        check1("R8", dout_vld, pv);
        checkw("R8", dout, pd);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) rd1(a, req);
        idle(2);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; ce_n = 1'b1; load_n = 1'b1; wr_n = 1'b1;
        lanes_n = '1; clken_n = 1'b0; out_en_n = 1'b0; sleep_req = 1'b0;
        burst_xor = 1'b0; din = '0;
        repeat (3) @(posedge clk);
        #1;
        check1("R12", dout_vld, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R12: continues straight after reset start nothing.
        for (int i = 0; i < 3; i++) issue(1'b1, 1'b0, 1'b0, AW'(i), 4'h0, 0, '0, '0, "R12");

        // R3: fill every word, back to back.
        for (int a = 0; a < DEPTH; a++) wr1(a, 4'h0, pat(a), "R3");
        idle(2);
        // R2: read every word, back to back.
        sweep("R2");

        // R1: reads and writes alternating every cycle.
        for (int i = 0; i < 8; i++) begin
            rd1(2*i, "R1");
            wr1(2*i + 1, 4'h0, pat(200 + i), "R1");
        end
        idle(2);

        // R4/R10: all sixteen lane patterns, each read right after its write.
        for (int i = 0; i < DEPTH; i++) begin
            wr1(i, LANES'(i*5), pat(300 + i), "R4");
            rd1(i, "R10");
        end
        idle(2);
        sweep("R4");

        // R5: linear bursts from every start word, ce_n high on continues.
        burst_xor = 1'b0;
        for (int s = 0; s < 4; s++) begin
            issue(1'b0, 1'b0, 1'b1, AW'(8 + s), 4'hF, 1, AW'(8 + s), '0, "R5");
            for (int k = 1; k < 4; k++)
                issue(1'b1, 1'b1, 1'b1, '0, 4'hF, 1, AW'(8 + ((s + k) % 4)), '0, "R5");
        end
        wr1(6, 4'h0, pat(400), "R5");
        for (int k = 1; k < 4; k++)
            issue(1'b1, 1'b1, 1'b0, '0, LANES'(k), 2, AW'(4 + ((2 + k) % 4)), pat(400 + k), "R5");
        idle(2);

        // R6: interleaved bursts.
        burst_xor = 1'b1;
        idle(1);
        for (int s = 0; s < 4; s++) begin
            issue(1'b0, 1'b0, 1'b1, AW'(8 + s), 4'hF, 1, AW'(8 + s), '0, "R6");
            for (int k = 1; k < 4; k++)
                issue(1'b1, 1'b1, 1'b1, '0, 4'hF, 1, AW'(8 + (s ^ k)), '0, "R6");
        end
        wr1(15, 4'h0, pat(500), "R6");
        for (int k = 1; k < 4; k++)
            issue(1'b1, 1'b0, 1'b0, '0, 4'h0, 2, AW'(12 + (3 ^ k)), pat(500 + k), "R6");
        idle(2);
        sweep("R6");
        burst_xor = 1'b0;

        // R7: continues after a deselect write nothing and read nothing.
        idle(1);
        for (int i = 0; i < 3; i++) issue(1'b1, 1'b0, 1'b0, AW'(i), 4'h0, 0, '0, '0, "R7");
        rd1(0, "R7");
        issue(1'b1, 1'b0, 1'b1, '0, 4'hF, 1, AW'(1), '0, "R7");
        idle(1);
        for (int i = 0; i < 3; i++) issue(1'b1, 1'b0, 1'b0, AW'(i), 4'h0, 0, '0, '0, "R7");
        idle(2);
        sweep("R7");

        // R8: freezes inside a read and between a write address and its data.
        rd1(5, "R8");
        stall(); stall(); stall();
        idle(1);
        stall();
        idle(1);
        stall(); stall();
        wr1(6, 4'h0, pat(600), "R8");
        stall();
        idle(1);
        stall(); stall();
        idle(1);
        rd1(6, "R8");
        idle(2);
        stall(); stall();
        idle(2);

        // R9: dummy read with the output disabled, then unclocked toggling.
        out_en_n = 1'b1;
        rd1(9, "R9");
        idle(2);
        #1 out_en_n = 1'b0;
        #1;
        check1("R9", dout_vld, 1'b1);
        checkw("R9", dout, ref_mem[9]);
        out_en_n = 1'b1;
        #1;
        check1("R9", dout_vld, 1'b0);
        out_en_n = 1'b0;
        idle(2);

        // R11: sleep with hostile traffic, then wake and verify the array.
        sleep_req = 1'b1;
        idle(2);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            clken_n = 1'b0; load_n = 1'b0; ce_n = 1'b0; wr_n = i[0];
            addr = AW'(i); lanes_n = '0; din = 36'hA_BCDE_F012;
            @(posedge clk);
            #1;
            check1("R11", dout_vld, 1'b0);
        end
        @(negedge clk);
        sleep_req = 1'b0;
        load_n = 1'b0; ce_n = 1'b1;
        @(posedge clk);
        #1;
        check1("R11", dout_vld, 1'b0);
        idle(3);
        sweep("R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule